// File: doc/BRIEF.md
# Low-Order Interleaved Banked Read Memory

This block stores words in several independent banks and serves a stream of word reads through one valid/ready request port. The low bits of each request address pick the bank, so a run of consecutive addresses visits every bank in turn. Each bank has a fixed access time and then a fixed recovery time. During those periods the bank takes no new request. Meanwhile the other banks keep accepting work, so one bank's recovery overlaps the accesses of its neighbours. With the default of four banks, two cycles of access and two of recovery, a sequential stream is accepted at one word per cycle.

Read data returns on a response port as a one-cycle valid pulse with data, strictly in the order the reads were accepted. Issued reads carry a sequence tag into a small reorder queue, and the queue drains from its head. A separate write port stores a word on any cycle and does not depend on bank timing. Reset clears all bank timing state and the response queue. It leaves the stored words alone.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The bank number is `req_addr[BANK_W-1:0]` and the word inside that bank is `req_addr[ADDR_W-1:BANK_W]` (BANK_W = log2 NUM_BANKS). The write port decodes `wr_addr` the same way. With four banks, addresses 0, 4 and 8 share bank 0, and addresses 0 and 1 use different banks.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored at `wr_addr`. A read accepted at any later edge returns that value.
- R3: A read accepted at clock edge k gives `rsp_valid` high for exactly one cycle, right after edge k+ACC_LAT+1, with the stored word on `rsp_data`.
- R4: After a bank accepts a read at edge k, it accepts no other read before edge k+ACC_LAT+PRE_LAT. If a read for that bank is pending, it is accepted at exactly that edge.
- R5: A read aimed at a bank that is free is accepted in the same cycle, while other banks are still accessing or recovering. With defaults, a stream of sequential addresses is accepted on every consecutive edge.
- R6: Responses come out in the order in which their reads were accepted, even when reads wait at different banks.
- R7: `req_ready` is low while the bank picked by `req_addr` is busy. The request waits until that bank frees up.
- R8: After reset, `req_ready` is high and `rsp_valid` is low. Reset leaves the stored words unchanged.
- R9: If a read is accepted at the same edge as a write to the same word, the read returns the old contents.
- R10: Every accepted read produces exactly one response, and no response appears without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Target bank free and queue has room |
| req_addr | input | ADDR_W | Read word address |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data, in request order |

## Verification
The assertions assume the following about the configuration:
- NUM_BANKS is a power of two.
- ACC_LAT and PRE_LAT are both at least one.

Under those assumptions, a bank can never take two reads on adjacent edges, and at most one bank finishes per cycle. The assertions also assume the response side always takes `rsp_data` when it is offered, because there is no back-pressure on that port. The stimulus keeps `req_addr` steady while a request waits. It pairs a read and a write on the same word only when that bank is idle, and it waits for all responses to drain before it applies a mid-run reset.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ACCESS,
        BK_RECOVER
    } bank_state_e;

    // bank number from the low address bits
    function automatic int unsigned bank_of(input int unsigned addr, input int unsigned bw);
        return addr & ((32'd1 << bw) - 32'd1);
    endfunction

    // word index from the remaining upper bits
    function automatic int unsigned word_of(input int unsigned addr, input int unsigned bw);
        return addr >> bw;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int DATA_W  = 16,
    parameter int TAG_W   = 3,
    parameter int ACC_LAT = 2,
    parameter int PRE_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              free,
    input  logic              issue,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic [TAG_W-1:0]  done_tag,
    output logic [DATA_W-1:0] done_data
);
    localparam int WORDS = 1 << IDX_W;
    localparam int MAXL  = max2(ACC_LAT, PRE_LAT);
    localparam int CNT_W = (MAXL > 1) ? $clog2(MAXL) : 1;
    localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACC_LAT - 1);
    localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_LAT - 1);

    logic [DATA_W-1:0] mem [WORDS];
    bank_state_e       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] hold_q;
    logic [TAG_W-1:0]  tag_q;

    // a bank in its last recovery cycle may already take the next read
    assign free = (state_q == BK_IDLE) ||
                  (state_q == BK_RECOVER && cnt_q == '0);
    assign done      = (state_q == BK_ACCESS) && (cnt_q == '0);
    assign done_tag  = tag_q;
    assign done_data = hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                BK_IDLE: begin
                    if (issue) begin
                        state_q <= BK_ACCESS;
                        cnt_q   <= ACC_LOAD;
                    end
                end
                BK_ACCESS: begin
                    if (cnt_q == '0) begin
                        state_q <= BK_RECOVER;
                        cnt_q   <= PRE_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                BK_RECOVER: begin
                    if (cnt_q == '0) begin
                        state_q <= issue ? BK_ACCESS : BK_IDLE;
                        cnt_q   <= issue ? ACC_LOAD : '0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= BK_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // storage: read sampled at issue, write any cycle
    always_ff @(posedge clk) begin
        if (issue) begin
            hold_q <= mem[rd_idx];
            tag_q  <= rd_tag;
        end
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/ilv_rsp_queue.sv
module ilv_rsp_queue #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc,
    output logic [$clog2(DEPTH)-1:0] alloc_tag,
    output logic                     has_room,
    input  logic                     put_vld,
    input  logic [$clog2(DEPTH)-1:0] put_tag,
    input  logic [DATA_W-1:0]        put_data,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data
);
    localparam int TAG_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] slot_d [DEPTH];
    logic [DEPTH-1:0]  slot_v;
    logic [TAG_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  count_q;
    logic              pop;

    assign alloc_tag = tail_q;
    assign has_room  = (count_q < CNT_W'(DEPTH));
    assign pop       = slot_v[head_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v    <= '0;
            head_q    <= '0;
            tail_q    <= '0;
            count_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= pop;
            if (pop) begin
                rsp_data       <= slot_d[head_q];
                slot_v[head_q] <= 1'b0;
                head_q         <= head_q + 1'b1;
            end
            if (put_vld) begin
                slot_v[put_tag] <= 1'b1;
            end
            if (alloc) begin
                tail_q <= tail_q + 1'b1;
            end
            case ({alloc, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (put_vld) begin
            slot_d[put_tag] <= put_data;
        end
    end

endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int ACC_LAT   = 2,
    parameter int PRE_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int IDX_W  = ADDR_W - BANK_W;
    localparam int QDEPTH = 2 * NUM_BANKS;
    localparam int TAG_W  = $clog2(QDEPTH);

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } completion_t;

    logic [BANK_W-1:0] rd_bank, wr_bank;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [NUM_BANKS-1:0] bank_free, bank_done;
    logic [TAG_W-1:0]  bank_tag  [NUM_BANKS];
    logic [DATA_W-1:0] bank_data [NUM_BANKS];
    logic              q_room, req_fire;
    logic [TAG_W-1:0]  next_tag;
    completion_t       cpl;

    assign rd_bank = BANK_W'(bank_of(32'(req_addr), BANK_W));
    assign rd_idx  = IDX_W'(word_of(32'(req_addr), BANK_W));
    assign wr_bank = BANK_W'(bank_of(32'(wr_addr), BANK_W));
    assign wr_idx  = IDX_W'(word_of(32'(wr_addr), BANK_W));

    assign req_ready = bank_free[rd_bank] && q_room;
    assign req_fire  = req_valid && req_ready;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .IDX_W  (IDX_W),
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .ACC_LAT(ACC_LAT),
            .PRE_LAT(PRE_LAT)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .free     (bank_free[b]),
            .issue    (req_fire && (rd_bank == BANK_W'(b))),
            .rd_idx   (rd_idx),
            .rd_tag   (next_tag),
            .wr_en    (wr_en && (wr_bank == BANK_W'(b))),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .done     (bank_done[b]),
            .done_tag (bank_tag[b]),
            .done_data(bank_data[b])
        );
    end

    // equal latencies and one issue per cycle: at most one bank completes
    always_comb begin
        cpl = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_done[b]) begin
                cpl.vld  = 1'b1;
                cpl.tag  = bank_tag[b];
                cpl.data = bank_data[b];
            end
        end
    end

    ilv_rsp_queue #(
        .DEPTH (QDEPTH),
        .DATA_W(DATA_W)
    ) u_queue (
        .clk      (clk),
        .rst      (rst),
        .alloc    (req_fire),
        .alloc_tag(next_tag),
        .has_room (q_room),
        .put_vld  (cpl.vld),
        .put_tag  (cpl.tag),
        .put_data (cpl.data),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 rsp_valid,
    input logic [NUM_BANKS-1:0] bank_done
);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic       fire;
    logic [7:0] pend_q;

    assign fire = req_valid && req_ready;

    // reads accepted but not yet answered
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + {7'd0, fire} - {7'd0, rsp_valid};
        end
    end

    // R8: no response in the cycle after reset
    a_r8_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid);

    // R4: a bank never accepts reads on adjacent edges
    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        fire |=> !(fire && (req_addr[BANK_W-1:0] == $past(req_addr[BANK_W-1:0]))));

    // R10: responses only for outstanding reads
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (pend_q != 8'd0));

    // R10: outstanding reads bounded by queue capacity
    a_r10_bounded_pending: assert property (@(posedge clk) disable iff (rst)
        pend_q <= 8'(2 * NUM_BANKS));

    // R6: one completion per cycle keeps the queue ordered
    a_r6_single_completion: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_done));

endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .bank_done(bank_done)
);

// File: tb/tb_ilv_mem_ctrl.sv
`timescale 1ns/1ps
module tb_ilv_mem_ctrl;
    localparam int NB  = 4;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int ACC = 2;
    localparam int PRE = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;

    always #4 clk = ~clk;

    ilv_mem_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW),
                   .ACC_LAT(ACC), .PRE_LAT(PRE)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0, n_acc = 0, n_rsp = 0;
    logic [DW-1:0] ref_mem [1 << AW];
    logic [DW-1:0] exp_d [$];
    int            exp_e [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // response monitor: order, data and latency (R2, R3, R6, R10)
    always @(negedge clk) begin
        logic [DW-1:0] d;
        int            e;
        if (!rst && rsp_valid) begin
            n_rsp++;
            if (exp_d.size() == 0) begin
                chk(1'b0, "R10 spurious response", 1, 0);
            end else begin
                d = exp_d.pop_front();
                e = exp_e.pop_front();
                chk(rsp_data == d, "R6/R2 response data in order", int'(rsp_data), int'(d));
                chk(cyc == e, "R3 response edge", cyc, e);
            end
        end
    end

    task automatic issue(input logic [AW-1:0] a, output int edge_no, output int waited);
        req_addr  = a;
        req_valid = 1'b1;
        waited    = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
            waited++;
        end
        edge_no = cyc + 1;
        exp_d.push_back(ref_mem[a]);
        exp_e.push_back(cyc + 1 + ACC + 1);
        n_acc++;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic drain(input string tag);
        req_valid = 1'b0;
        repeat (ACC + PRE + 4) @(negedge clk);
        chk(exp_d.size() == 0, tag, exp_d.size(), 0);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R8 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R8 no response after reset", int'(rsp_valid), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < (1 << AW); i++) wr(AW'(i), DW'(16'h5A00 ^ (i * 263)));
        repeat (2) @(negedge clk);
    endtask

    task automatic t_bank_map();
        int e0, e1, w;
        issue(8'd0, e0, w);
        issue(8'd1, e1, w);
        chk(w == 0 && e1 - e0 == 1, "R1 addresses 0 and 1 in different banks", e1 - e0, 1);
        issue(8'd4, e1, w);
        chk(e1 - e0 == ACC + PRE, "R1 addresses 0 and 4 share a bank", e1 - e0, ACC + PRE);
        drain("R10 bank map drained");
    endtask

    task automatic t_seq();
        int e, w, tot = 0;
        for (int i = 16; i < 32; i++) begin
            issue(AW'(i), e, w);
            tot += w;
        end
        chk(tot == 0, "R5 sequential stream without stall", tot, 0);
        drain("R10 sequential drained");
    endtask

    task automatic t_same_bank();
        int e0, e1, e2, w;
        issue(8'd0, e0, w);
        issue(8'd4, e1, w);
        chk(w == ACC + PRE - 1, "R7 ready low while bank busy", w, ACC + PRE - 1);
        chk(e1 - e0 == ACC + PRE, "R4 reissue spacing", e1 - e0, ACC + PRE);
        issue(8'd8, e2, w);
        chk(e2 - e1 == ACC + PRE, "R4 reissue spacing second", e2 - e1, ACC + PRE);
        drain("R10 same bank drained");
    endtask

    task automatic t_mixed();
        int e, w;
        logic [AW-1:0] seq [6] = '{8'd40, 8'd44, 8'd41, 8'd45, 8'd48, 8'd42};
        foreach (seq[i]) issue(seq[i], e, w);
        drain("R6 mixed stalls drained in order");
    endtask

    task automatic t_raw();
        int e, w;
        logic [DW-1:0] old_v;
        old_v   = ref_mem[9];
        wr_en   = 1'b1; wr_addr = 8'd9; wr_data = 16'hBEEF;
        issue(8'd9, e, w);
        wr_en   = 1'b0;
        ref_mem[9] = 16'hBEEF;
        chk(w == 0, "R9 read with write accepted", w, 0);
        chk(old_v != 16'hBEEF, "R9 old value differs", int'(old_v), 0);
        drain("R9 same-word read returns old data");
        issue(8'd9, e, w);
        drain("R2 later read returns written data");
    endtask

    task automatic t_mid_reset();
        int e, w;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, "R8 ready after mid-run reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R8 idle response after mid-run reset", int'(rsp_valid), 0);
        issue(8'd3, e, w);
        drain("R8 contents kept across reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_bank_map();
        t_seq();
        t_same_bank();
        t_mixed();
        t_raw();
        t_mid_reset();
        chk(n_rsp == n_acc, "R10 one response per read", n_rsp, n_acc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule